// File: doc/BRIEF.md
# BCD Timekeeper with Read Snapshot

This block keeps time of day as binary-coded decimal seconds, minutes and hours. A prescale tick input is divided by `SUB_STEPS` to form the one-second step (with `SUB_STEPS = 1` the input is itself the 1 Hz tick). Hours run in either a 24-hour format or a 12-hour format with an AM/PM flag. The format is chosen by a bit held in the hours register itself.

Reads never see the live counters. A one-cycle `bus_start` pulse, issued when a bus transaction opens, copies the running time into a shadow set. Every read during that transaction returns the copy while the live counters keep running. A carry that ripples through seconds, minutes and hours in the middle of a transaction therefore cannot give a torn value. Writes go straight to the live counters and restart the sub-second phase, so a freshly written time stands for one whole second.

Top module: `rtc_time_core`

## Requirements
- R1: After reset the live time is 00:00:00 in 24-hour format and the sub-second phase is zero. The shadow set is all zero, so every read returns 0x00.
- R2: The seconds field steps once for every `SUB_STEPS` cycles with `tick_in` high. In a cycle without `tick_in` and without a write, the live time does not change.
- R3: Seconds (address 0) and minutes (address 1) are BCD in bits 6:0, with tens in bits 6:4 and ones in bits 3:0. Each counts 00 to 59. Seconds carry into minutes when they wrap from 59 to 00, and minutes carry into hours the same way.
- R4: Hours are at address 2. With bit 6 = 0 the format is 24-hour: bits 5:4 hold the tens (0 to 2) and bits 3:0 the ones. The count runs 00 to 23 and then wraps to 00.
- R5: With hours bit 6 = 1 the format is 12-hour: bit 5 is PM (1 = PM) and bits 4:0 hold the BCD hour. The count runs 12, 01, 02 … 11, and PM inverts on the step from 11 to 12.
- R6: An hours write stores bits 6:0 exactly as given. Changing bit 6 does not convert the stored hour.
- R7: A cycle with `bus_start` high copies the live time, as it stood before that clock edge, into the shadow set. From the next cycle on, `reg_rdata` shows the shadow register selected by `reg_addr`.
- R8: The shadow set keeps its value through ticks and writes until the next `bus_start`.
- R9: A write to address 0, 1 or 2 loads that live field from `reg_wdata[6:0]` and clears the sub-second phase. No step happens in the write cycle, so the next seconds step needs a further `SUB_STEPS` ticks.
- R10: Address 3 reads 0x00, and a write to it changes neither the time nor the sub-second phase. Bit 7 of every read is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | 1 | Sub-second prescale tick, one cycle wide |
| bus_start | input | 1 | Transaction-start pulse that captures the shadow set |
| reg_addr | input | 2 | Register select: 0 seconds, 1 minutes, 2 hours, 3 unused |
| reg_wr | input | 1 | Write strobe for the live counters |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data from the shadow set |

## Verification
The time is walked across each carry boundary: seconds alone, 59:59 into the hour, 09→10 and 19→20, and 23:59:59 back to midnight. It is also walked across the three 12-hour turning points (11→12 with PM inverting, 12→01, and 11 PM→12 AM). Together these separate the wrap values and the ones-to-tens carry of each field. Ticks are applied every cycle, every other cycle and not at all, which tells the divide-by-`SUB_STEPS` timing apart from a raw tick count. Runs that capture on every cycle are set against runs with a single capture while the time advances and is rewritten, to show that reads come only from the copy. Writes placed at different sub-second phases show that the phase restarts.

// File: rtl/rtc_time_pkg.sv
package rtc_time_pkg;

  localparam int FIELD_W = 7;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_SEC  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MIN  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOUR = 2'd2;

  typedef struct packed {
    logic [FIELD_W-1:0] hrs;
    logic [FIELD_W-1:0] mins;
    logic [FIELD_W-1:0] secs;
  } rtc_time_t;

  localparam int TIME_W = $bits(rtc_time_t);

endpackage

// File: rtl/bcd_mod_counter.sv
module bcd_mod_counter #(
  parameter int LAST_TENS = 5,
  parameter int LAST_ONES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [6:0] load_val,
  input  logic       inc,
  output logic [6:0] q,
  output logic       wrap
);

  localparam logic [2:0] TENS_MAX = 3'(LAST_TENS);
  localparam logic [3:0] ONES_MAX = 4'(LAST_ONES);

  logic [6:0] q_d;
  logic       at_last;

  assign at_last = (q[6:4] >= TENS_MAX) && (q[3:0] >= ONES_MAX);
  assign wrap    = inc && !load && at_last;

  always_comb begin
    q_d = q;
    if (load) begin
      q_d = load_val;
    end else if (inc) begin
      if (at_last) begin
        q_d = 7'h00;
      end else if (q[3:0] >= 4'd9) begin
        q_d = {q[6:4] + 3'd1, 4'd0};
      end else begin
        q_d = {q[6:4], q[3:0] + 4'd1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 7'h00;
    end else if (load || inc) begin
      q <= q_d;
    end
  end

  // R2
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(q));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (q == 7'h00));

  // R9
  load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));

endmodule

// File: rtl/hour_counter.sv
module hour_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [6:0] load_val,
  input  logic       inc,
  output logic [6:0] q
);

  logic [6:0] q_d;
  logic       fmt12;
  logic       pm_flag;
  logic [4:0] h12;
  logic [1:0] tens24;
  logic [3:0] ones;

  assign fmt12   = q[6];
  assign pm_flag = q[5];
  assign h12     = q[4:0];
  assign tens24  = q[5:4];
  assign ones    = q[3:0];

  always_comb begin
    q_d = q;
    if (load) begin
      q_d = load_val;
    end else if (inc) begin
      if (fmt12) begin
        if (h12 == 5'h12) begin
          q_d = {1'b1, pm_flag, 5'h01};
        end else if (h12 == 5'h11) begin
          q_d = {1'b1, !pm_flag, 5'h12};
        end else if (ones >= 4'd9) begin
          q_d = {1'b1, pm_flag, 5'h10};
        end else begin
          q_d = {1'b1, pm_flag, h12[4], ones + 4'd1};
        end
      end else begin
        if (q[5:0] == 6'h23) begin
          q_d = 7'h00;
        end else if (ones >= 4'd9) begin
          q_d = {1'b0, tens24 + 2'd1, 4'd0};
        end else begin
          q_d = {1'b0, tens24, ones + 4'd1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 7'h00;
    end else if (load || inc) begin
      q <= q_d;
    end
  end

  // R5
  pm_flip_at_twelve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && fmt12 && h12 == 5'h11) |=> (q[4:0] == 5'h12 && q[5] != $past(q[5])));

  // R4
  midnight_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && q == 7'h23) |=> (q == 7'h00));

  // R6
  mode_kept_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (q[6] == $past(q[6])));

endmodule

// File: rtl/time_shadow.sv
module time_shadow #(
  parameter int WIDTH = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] live,
  output logic [WIDTH-1:0] shadow
);

  logic [WIDTH-1:0] shadow_d;

  always_comb begin
    shadow_d = shadow;
    if (capture) begin
      shadow_d = live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (capture) begin
      shadow <= shadow_d;
    end
  end

  // R7
  copy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (shadow == $past(live)));

  // R8
  hold_between_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(shadow));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_time_pkg::*;
#(
  parameter int SUB_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int SUB_W = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_STEPS - 1);

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic wr_sec, wr_min, wr_hour, wr_time;

  assign wr_sec  = reg_wr && (reg_addr == ADDR_SEC);
  assign wr_min  = reg_wr && (reg_addr == ADDR_MIN);
  assign wr_hour = reg_wr && (reg_addr == ADDR_HOUR);
  assign wr_time = wr_sec || wr_min || wr_hour;

  logic [SUB_W-1:0] sub_q, sub_d;
  logic             sub_en;
  logic             sec_step;

  assign sec_step = tick_in && !wr_time && (sub_q == SUB_LAST);
  assign sub_en   = wr_time || tick_in;

  always_comb begin
    sub_d = sub_q;
    if (wr_time) begin
      sub_d = '0;
    end else if (tick_in) begin
      sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sub_q <= '0;
    end else if (sub_en) begin
      sub_q <= sub_d;
    end
  end

  rtc_time_t live_time;
  rtc_time_t shadow_time;
  logic      sec_wrap, min_wrap;

  bcd_mod_counter #(.LAST_TENS(5), .LAST_ONES(9)) u_sec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (wr_sec),
    .load_val (reg_wdata[FIELD_W-1:0]),
    .inc      (sec_step),
    .q        (live_time.secs),
    .wrap     (sec_wrap)
  );

  bcd_mod_counter #(.LAST_TENS(5), .LAST_ONES(9)) u_min (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (wr_min),
    .load_val (reg_wdata[FIELD_W-1:0]),
    .inc      (sec_wrap),
    .q        (live_time.mins),
    .wrap     (min_wrap)
  );

  hour_counter u_hour (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (wr_hour),
    .load_val (reg_wdata[FIELD_W-1:0]),
    .inc      (min_wrap),
    .q        (live_time.hrs)
  );

  time_shadow #(.WIDTH(TIME_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .capture (bus_start),
    .live    (live_time),
    .shadow  (shadow_time)
  );

  always_comb begin
    case (reg_addr)
      ADDR_SEC:  reg_rdata = {1'b0, shadow_time.secs};
      ADDR_MIN:  reg_rdata = {1'b0, shadow_time.mins};
      ADDR_HOUR: reg_rdata = {1'b0, shadow_time.hrs};
      default:   reg_rdata = '0;
    endcase
  end

  // R9
  phase_cleared_on_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_time |=> (sub_q == '0));

  // R2
  time_idle_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tick_in && !wr_time) |=> $stable(live_time));

  // R10
  unused_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == 2'd3 && !tick_in) |=> ($stable(live_time) && $stable(sub_q)));

  // R10
  always_comb begin
    top_bit_zero_chk: assert (reg_rdata[7] == 1'b0 || !rst_sync_n);
  end

endmodule

// File: tb/rtc_time_core_test.sv
module rtc_time_core_test;

  localparam int SUB = 4;

  logic       clk;
  logic       rst_n;
  logic       tick_in;
  logic       bus_start;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  rtc_time_core #(.SUB_STEPS(SUB)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .bus_start (bus_start),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  string tag   = "R1";

  // behavioural reference state
  int m_sec, m_min, m_hr, m_sub;
  bit m_12h, m_pm;
  logic [7:0] m_sh [3];

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] hour_byte();
    logic [7:0] b;
    b = to_bcd(m_hr);
    if (m_12h) return {2'b01, m_pm, b[4:0]};
    return {2'b00, b[5:0]};
  endfunction

  task automatic advance_second();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0;
      m_min++;
      if (m_min == 60) begin
        m_min = 0;
        if (m_12h) begin
          if (m_hr == 12) m_hr = 1;
          else if (m_hr == 11) begin m_hr = 12; m_pm = !m_pm; end
          else m_hr++;
        end else begin
          m_hr = (m_hr + 1) % 24;
        end
      end
    end
  endtask

  task automatic model_update(input logic t, input logic s, input logic w,
                              input logic [1:0] a, input logic [7:0] d);
    if (s) begin
      m_sh[0] = to_bcd(m_sec);
      m_sh[1] = to_bcd(m_min);
      m_sh[2] = hour_byte();
    end
    if (w && a != 2'd3) begin
      m_sub = 0;
      case (a)
        2'd0: m_sec = int'(d[6:4]) * 10 + int'(d[3:0]);
        2'd1: m_min = int'(d[6:4]) * 10 + int'(d[3:0]);
        default: begin
          m_12h = d[6];
          if (d[6]) begin
            m_pm = d[5];
            m_hr = int'(d[4]) * 10 + int'(d[3:0]);
          end else begin
            m_hr = int'(d[5:4]) * 10 + int'(d[3:0]);
          end
        end
      endcase
    end else if (t) begin
      if (m_sub == SUB - 1) begin
        m_sub = 0;
        advance_second();
      end else begin
        m_sub++;
      end
    end
  endtask

  task automatic compare(input logic [1:0] a);
    logic [7:0] exp;
    exp = (a == 2'd3) ? 8'h00 : m_sh[a];
    n_vec++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic step(input logic t, input logic s, input logic w,
                      input logic [1:0] a, input logic [7:0] d);
    tick_in = t; bus_start = s; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_update(t, s, w, a, d);
    @(negedge clk);
    compare(a);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic snap_read();
    step(1'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 2'(i), 8'h00);
  endtask

  // n cycles, tick every 'period' cycles, capture each cycle if cap, address rotating
  task automatic run(input int n, input int period, input bit cap);
    for (int i = 0; i < n; i++)
      step((i % period) == 0, cap, 1'b0, 2'(i % 3), 8'h00);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(2'd2, h);
    wr(2'd1, m);
    wr(2'd0, s);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    m_sec = 0; m_min = 0; m_hr = 0; m_sub = 0; m_12h = 0; m_pm = 0;
    for (int i = 0; i < 3; i++) m_sh[i] = 8'h00;
    tick_in = 0; bus_start = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state through reads, then a capture of the live reset time
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 2'(i), 8'h00);
    snap_read();

    // R2: ticks every other cycle and none at all, captured each cycle
    tag = "R2";
    run(40, 2, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 2'd0, 8'h00);

    // R3: seconds and minutes carries
    tag = "R3";
    set_time(8'h05, 8'h00, 8'h57);
    run(24, 1, 1'b1);
    set_time(8'h07, 8'h59, 8'h58);
    run(16, 1, 1'b1);

    // R4: 24-hour digit carries and midnight wrap
    tag = "R4";
    set_time(8'h09, 8'h59, 8'h59);
    run(8, 1, 1'b1);
    set_time(8'h19, 8'h59, 8'h59);
    run(8, 1, 1'b1);
    set_time(8'h23, 8'h59, 8'h58);
    run(16, 1, 1'b1);
    snap_read();

    // R5: 12-hour sequence, 11 AM -> 12 PM, 12 PM -> 01 PM, 11 PM -> 12 AM, 09 -> 10
    tag = "R5";
    set_time(8'h51, 8'h59, 8'h58);
    run(12, 1, 1'b1);
    snap_read();
    set_time(8'h72, 8'h59, 8'h59);
    run(8, 1, 1'b1);
    snap_read();
    set_time(8'h71, 8'h59, 8'h59);
    run(8, 1, 1'b1);
    snap_read();
    set_time(8'h69, 8'h59, 8'h59);
    run(8, 1, 1'b1);
    snap_read();

    // R6: changing the format bit keeps the hour bits as written
    tag = "R6";
    wr(2'd2, 8'h15);
    snap_read();
    wr(2'd2, 8'h45);
    snap_read();

    // R8: single capture, then time runs and is rewritten while reads stay put
    tag = "R8";
    set_time(8'h10, 8'h20, 8'h30);
    snap_read();
    run(30, 1, 1'b0);
    wr(2'd0, 8'h11);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 2'(i), 8'h00);
    snap_read();

    // R9: writes at several sub-second phases restart the phase
    tag = "R9";
    for (int ph = 0; ph < SUB; ph++) begin
      wr(2'd0, 8'h20);
      for (int i = 0; i < ph; i++) step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
      step(1'b1, 1'b1, 1'b1, 2'd1, 8'h44);
      run(2 * SUB + 2, 1, 1'b1);
    end

    // R10: address 3 reads zero, its writes change nothing
    tag = "R10";
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
    step(1'b0, 1'b0, 1'b1, 2'd3, 8'hFF);
    step(1'b1, 1'b0, 1'b1, 2'd3, 8'h7F);
    step(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);
    run(12, 1, 1'b1);
    snap_read();

    // R3: long run through many minute carries in 24-hour format
    tag = "R3";
    set_time(8'h22, 8'h00, 8'h00);
    run(4000 * SUB, 1, 1'b1);
    snap_read();

    finish_run();
  end

endmodule